// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog timer on a simple register bus. The bus has an address, a write strobe, write data and combinational read data, and every access completes in one cycle. A down-counter is loaded from a reload register only when software writes a fixed key value to the restart register. While counting is enabled, the counter steps down on every clock or on a slow tick input, as a control bit selects.

A counting step taken while the count is already zero is an expiry. On expiry the counter reloads and keeps running. Each expiry action enabled in the control register then raises its output for one clock: a reset request, an interrupt and an external watchdog strobe. A sticky expired flag stays set until the next valid restart. A level output tells the reset controller whether the requested reset covers only the SoC or the whole chip. The reset controller, clock generation and bus bridging sit outside this block.

Software starts the timer with this sequence: clear control, write the reload value, write the key, then write control with the enable bit set.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the control, reload and count registers are zero. Every output is low, and a read at any offset returns 0.
- R2: Registers sit at word offsets 0x0 (count, read-only), 0x4 (reload, read/write), 0x8 (restart, reads 0) and 0xC (control, bits 5:0, upper bits read 0). Writes to offset 0x0 have no effect.
- R3: Writing exactly 0x4755 to offset 0x8 copies the reload value into the count at that clock edge. Any other value written there leaves the count unchanged.
- R4: A write to the reload register does not change the running count until the next valid restart.
- R5: Control bit 0 enables counting and reads back as written. While it is clear, the count holds its value.
- R6: While control bit 4 is set, the count steps only at clock edges where `tick_1mhz` is high. While it is clear, the count steps at every clock edge.
- R7: A step taken while the count is zero is an expiry, and it loads the count from the reload register. After a restart with reload N, the first expiry comes at the (N+1)th step.
- R8: On expiry, `rst_req`, `irq` and `wdt_strobe` go high for the following cycle, each only if its enable is set (control bits 1, 2 and 3 respectively). With its enable clear, an output stays low.
- R9: `expired` is set by an expiry and stays set until a valid restart write clears it. Invalid key writes do not clear it.
- R10: `full_chip` follows control bit 5: 1 selects a full-chip reset, 0 an SoC-only reset.
- R11: The start sequence (control 0, reload N, key, control with enable) gives an expiry N+1 clocks after the enabling write when counting at clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe, single cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_1mhz | input | 1 | Slow count tick, one cycle high per period |
| rst_req | output | 1 | Reset request pulse on expiry |
| irq | output | 1 | Interrupt pulse on expiry |
| wdt_strobe | output | 1 | External watchdog pulse on expiry |
| full_chip | output | 1 | Reset scope: 1 full chip, 0 SoC only |
| expired | output | 1 | Sticky expiry flag |

## Verification
The hardest cases to reach from the ports are the exact expiry edge, where the count wraps from zero back to the reload value, and the rule that a reload write during a run has no effect until the next restart. The bench runs the start sequence for every reload value from 0 to 5 combined with every pattern of the three action enables. For each run it computes the expiry cycle as N+1 clocks after the enabling write, then checks the count and the pulses on the cycle before expiry, on the expiry cycle and on the cycle after. Separate runs change the reload and write bad keys in the middle of a count, and pace the count with single tick pulses.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

   // word indices of the registers (byte offset >> 2)
   localparam int unsigned IDX_COUNT   = 0;
   localparam int unsigned IDX_RELOAD  = 1;
   localparam int unsigned IDX_RESTART = 2;
   localparam int unsigned IDX_CTRL    = 3;

   localparam int unsigned CTRL_W = 6;

   // control register, bit 5 down to bit 0
   typedef struct packed {
      logic full_chip;
      logic tick_sel;
      logic strobe_en;
      logic irq_en;
      logic rst_en;
      logic enable;
   } ctrl_t;

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
   import kwd_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter logic [DATA_W-1:0] KEY = 'h4755
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  count_q,
   output ctrl_t             ctrl_q,
   output logic [CNT_W-1:0]  reload_q,
   output logic              restart_hit
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [IDX_W-1:0] idx;
   logic             wr_reload;
   logic             wr_ctrl;

   assign idx         = bus_addr[ADDR_W-1:2];
   assign wr_reload   = bus_we && (idx == IDX_W'(IDX_RELOAD));
   assign wr_ctrl     = bus_we && (idx == IDX_W'(IDX_CTRL));
   assign restart_hit = bus_we && (idx == IDX_W'(IDX_RESTART)) && (bus_wdata == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else begin
         if (wr_ctrl)
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (wr_reload)
            reload_q <= bus_wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (idx)
         IDX_W'(IDX_COUNT):  bus_rdata = DATA_W'(count_q);
         IDX_W'(IDX_RELOAD): bus_rdata = DATA_W'(reload_q);
         IDX_W'(IDX_CTRL):   bus_rdata = DATA_W'(ctrl_q);
         default:            bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/kwd_tick.sv
module kwd_tick #(
   parameter bit TICK_SYNC = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_step
);

   generate
      if (TICK_SYNC) begin : g_sync
         // asynchronous tick: two-flop synchronizer plus rising-edge detect
         logic [2:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[1:0], tick_in};
         end
         assign tick_step = sh_q[1] && !sh_q[2];
      end else begin : g_direct
         // tick already a one-cycle strobe in this clock domain
         assign tick_step = tick_in;
      end
   endgenerate

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
   import kwd_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctrl_t            ctrl_q,
   input  logic             tick_step,
   input  logic             restart_hit,
   input  logic [CNT_W-1:0] reload_q,
   output logic [CNT_W-1:0] count_q,
   output logic             fire
);

   logic step;

   assign step = ctrl_q.enable && (ctrl_q.tick_sel ? tick_step : 1'b1);
   assign fire = step && !restart_hit && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (restart_hit || fire)
         count_q <= reload_q;
      else if (step)
         count_q <= count_q - 1'b1;
   end

endmodule

// File: rtl/kwd_actions.sv
module kwd_actions
   import kwd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  ctrl_t ctrl_q,
   input  logic  fire,
   input  logic  restart_hit,
   output logic  rst_req,
   output logic  irq,
   output logic  wdt_strobe,
   output logic  expired
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req    <= 1'b0;
         irq        <= 1'b0;
         wdt_strobe <= 1'b0;
         expired    <= 1'b0;
      end else begin
         rst_req    <= fire && ctrl_q.rst_en;
         irq        <= fire && ctrl_q.irq_en;
         wdt_strobe <= fire && ctrl_q.strobe_en;
         if (restart_hit)
            expired <= 1'b0;
         else if (fire)
            expired <= 1'b1;
      end
   end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import kwd_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 32,
   parameter logic [DATA_W-1:0] KEY = 'h4755,
   parameter bit          TICK_SYNC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_1mhz,
   output logic              rst_req,
   output logic              irq,
   output logic              wdt_strobe,
   output logic              full_chip,
   output logic              expired
);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("keyed_watchdog: ADDR_W must cover four word registers");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("keyed_watchdog: CNT_W must be between 1 and DATA_W");
      end
      if (DATA_W < CTRL_W) begin : g_bad_data
         $error("keyed_watchdog: DATA_W too narrow for control register");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] count_q;
   logic             restart_hit;
   logic             tick_step;
   logic             fire;

   kwd_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .count_q(count_q),
      .ctrl_q(ctrl_q), .reload_q(reload_q), .restart_hit(restart_hit)
   );

   kwd_tick #(.TICK_SYNC(TICK_SYNC)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_1mhz), .tick_step(tick_step)
   );

   kwd_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .tick_step(tick_step),
      .restart_hit(restart_hit), .reload_q(reload_q),
      .count_q(count_q), .fire(fire)
   );

   kwd_actions u_actions (
      .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .fire(fire),
      .restart_hit(restart_hit), .rst_req(rst_req), .irq(irq),
      .wdt_strobe(wdt_strobe), .expired(expired)
   );

   assign full_chip = ctrl_q.full_chip;

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_en,
   input logic             ctrl_scope,
   input logic             restart_hit,
   input logic [CNT_W-1:0] count_q,
   input logic [CNT_W-1:0] reload_q,
   input logic             rst_req,
   input logic             irq,
   input logic             wdt_strobe,
   input logic             full_chip,
   input logic             expired
);

   // valid key loads the reload value and clears the flag
   assert_key_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart_hit |=> (count_q == $past(reload_q)) && !expired);

   // disabled counter holds unless a valid restart arrives
   assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && !restart_hit) |=> $stable(count_q));

   // any action pulse follows a step from zero, and reloads the count
   assert_pulse_from_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || irq || wdt_strobe) |-> ($past(count_q) == '0) && (count_q == $past(reload_q)));

   // the sticky flag is set whenever an action pulse appears
   assert_flag_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req || irq || wdt_strobe) |-> expired);

   // the flag stays set until a valid restart
   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !restart_hit) |=> expired);

   // scope output tracks the control bit
   assert_scope_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      full_chip == ctrl_scope);

endmodule

bind keyed_watchdog kwd_checker #(.CNT_W(CNT_W)) u_kwd_checker (
   .clk(clk), .rst_n(rst_n),
   .ctrl_en(ctrl_q.enable), .ctrl_scope(ctrl_q.full_chip),
   .restart_hit(restart_hit), .count_q(count_q), .reload_q(reload_q),
   .rst_req(rst_req), .irq(irq), .wdt_strobe(wdt_strobe),
   .full_chip(full_chip), .expired(expired)
);

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;

   localparam logic [31:0] KEY = 32'h4755;
   localparam logic [3:0] A_CNT = 4'h0, A_RLD = 4'h4, A_RST = 4'h8, A_CTL = 4'hC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_1mhz = 1'b0;
   logic        rst_req, irq, wdt_strobe, full_chip, expired;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   keyed_watchdog i_keyed_watchdog (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1mhz(tick_1mhz),
      .rst_req(rst_req), .irq(irq), .wdt_strobe(wdt_strobe),
      .full_chip(full_chip), .expired(expired)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the write edge
   task automatic bw(input logic [3:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // R11 start sequence, then expiry timing and action pulses (R7, R8)
   task automatic run_expiry(input int n, input logic [2:0] acts, input logic scope);
      logic [31:0] v;
      bw(A_CTL, 32'h0);
      bw(A_RLD, 32'(n));
      bw(A_RST, KEY);
      bw(A_CTL, {26'b0, scope, 1'b0, acts, 1'b1});
      repeat (n) @(negedge clk);
      rd(A_CNT, v);
      chk("R11 count zero before expiry", v, 32'h0);
      chk("R8 no pulse before expiry", {29'b0, wdt_strobe, irq, rst_req}, 32'h0);
      chk("R9 flag clear before expiry", {31'b0, expired}, 32'h0);
      @(negedge clk);
      rd(A_CNT, v);
      chk("R7 count reloads on expiry", v, 32'(n));
      chk("R8 action pulses", {29'b0, wdt_strobe, irq, rst_req}, {29'b0, acts});
      chk("R9 flag set on expiry", {31'b0, expired}, 32'h1);
      chk("R10 scope output", {31'b0, full_chip}, {31'b0, scope});
      if (n > 0) begin
         @(negedge clk);
         chk("R8 pulse lasts one cycle", {29'b0, wdt_strobe, irq, rst_req}, 32'h0);
      end
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         failures++;
         $display("FAIL watchdog timeout actual=%0d expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(4'(a * 4), v);
         chk("R1 reset read", v, 32'h0);
      end
      chk("R1 reset outputs", {27'b0, rst_req, irq, wdt_strobe, full_chip, expired}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(A_CTL, v);
      chk("R1 control zero after release", v, 32'h0);

      // near-exhaustive sweep: reload 0..5 x every action pattern
      for (int n = 0; n <= 5; n++)
         for (int acts = 0; acts < 8; acts++)
            run_expiry(n, 3'(acts), 1'((n + acts) & 1));

      // R2 control readback, upper bits ignored
      bw(A_CTL, 32'hFFFF_FFC0);
      rd(A_CTL, v);
      chk("R2 control upper bits read zero", v, 32'h0);

      // R4 / R3 / R2 mid-run behaviour at clock rate
      bw(A_RLD, 32'd20);
      bw(A_RST, KEY);
      bw(A_CTL, 32'h1);
      rd(A_CTL, v);
      chk("R5 enable reads back", v, 32'h1);
      repeat (2) @(negedge clk);
      rd(A_CNT, v);
      chk("R5 counting every clock", v, 32'd18);
      bw(A_RLD, 32'd5);
      rd(A_CNT, v);
      chk("R4 reload write leaves count", v, 32'd17);
      rd(A_RLD, v);
      chk("R2 reload reads back", v, 32'd5);
      bw(A_RST, 32'h4754);
      rd(A_CNT, v);
      chk("R3 bad key ignored", v, 32'd16);
      rd(A_RST, v);
      chk("R2 restart reads zero", v, 32'h0);
      bw(A_RST, KEY);
      rd(A_CNT, v);
      chk("R3 key loads reload", v, 32'd5);
      bw(A_CNT, 32'hFFFF);
      rd(A_CNT, v);
      chk("R2 count write ignored", v, 32'd4);

      // R5 disable freezes count
      bw(A_CTL, 32'h0);
      repeat (4) @(negedge clk);
      rd(A_CNT, v);
      chk("R5 disabled count holds", v, 32'd3);

      // R9 flag survives bad key, cleared by good key
      run_expiry(2, 3'b000, 1'b0);
      bw(A_CTL, 32'h0);
      bw(A_RST, 32'h0000_4756);
      chk("R9 flag kept on bad key", {31'b0, expired}, 32'h1);
      bw(A_RST, KEY);
      chk("R9 flag cleared by key", {31'b0, expired}, 32'h0);

      // R6 tick-paced counting
      bw(A_RLD, 32'd10);
      bw(A_RST, KEY);
      bw(A_CTL, 32'h11);
      repeat (3) @(negedge clk);
      rd(A_CNT, v);
      chk("R6 no step without tick", v, 32'd10);
      tick_1mhz = 1'b1;
      @(negedge clk);
      tick_1mhz = 1'b0;
      rd(A_CNT, v);
      chk("R6 one step per tick", v, 32'd9);
      tick_1mhz = 1'b1;
      repeat (3) @(negedge clk);
      tick_1mhz = 1'b0;
      rd(A_CNT, v);
      chk("R6 three ticks three steps", v, 32'd6);
      bw(A_CTL, 32'h1);
      rd(A_CNT, v);
      chk("R6 clock rate ignores idle tick", v, 32'd6);
      @(negedge clk);
      rd(A_CNT, v);
      chk("R6 clock rate steps", v, 32'd5);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule